// File: doc/BRIEF.md
# Macro-Fusion Predecode Grouper

This block stands between a queue of predecoded instruction records and a four-slot decode stage. It looks at a window of five records every cycle. Each record carries a valid flag, a two-bit instruction class and a byte length. The block decides which records go to the decoders in this cycle and packs them, in program order, into up to four decode slots.

A flag-setting compare or test that is directly followed by a conditional jump can be merged into one fused slot. That slot stands for both instructions and is decoded as a single operation. The block forms at most one fused slot per cycle. A busy cycle can therefore take five records: three ordinary slots plus one fused slot.

The block reports how many records it took. It does this combinationally, in the same cycle, so that the queue can advance its read pointer at the clock edge. The slots are registered and reach the decoders one cycle later. When the decode stage is not ready, the block takes nothing and presents no slots in the next cycle.

Top module: `fuse_grouper`

## Requirements
- R1: After reset, all `slot_valid` bits are 0.
- R2: When no pair can fuse, at most four records are placed, one per slot. Slot k carries window position k, that record's length, and `slot_fused`=0.
- R3: Class value 1 means compare/test and class value 2 means conditional jump; classes 0 and 3 are ordinary. A valid class-1 record at position p followed by a valid class-2 record at p+1 becomes one slot with `slot_fused`=1, `slot_pos`=p and `slot_len` equal to the sum of both lengths.
- R4: At most one slot per cycle is fused. A second eligible pair in the same window is placed as ordinary slots.
- R5: At most five records are taken in one cycle, which happens only as three ordinary slots plus one fused slot.
- R6: Records are taken strictly in window order. The first invalid record ends the cycle's taking, even if later records are valid.
- R7: A class-1 record whose successor is invalid, or which lies at the last window position, is sent as an ordinary slot.
- R8: A class-2 record that is not directly preceded by an unfused class-1 record, or a class-1 record followed by a non-class-2 record, is sent as an ordinary slot.
- R9: While `dec_ready` is 0, `take_cnt` is 0, and in the next cycle all `slot_valid` bits are 0.
- R10: `take_cnt` in a cycle equals the number of ordinary slots plus twice the number of fused slots presented in the following cycle.
- R11: Occupied slots are packed from slot 0 upward with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid | input | 5 | Valid flag per window position (bit i = position i) |
| rec_cls | input | 10 | Two-bit class per position (bits 2i+1:2i) |
| rec_len | input | 20 | Four-bit byte length per position (bits 4i+3:4i) |
| dec_ready | input | 1 | Decode stage can accept slots this cycle |
| take_cnt | output | 3 | Records taken this cycle (combinational) |
| slot_valid | output | 4 | Slot occupied, registered |
| slot_fused | output | 4 | Slot holds a fused pair |
| slot_pos | output | 12 | Window position of the slot's first record (3 bits per slot) |
| slot_len | output | 20 | Total byte length of the slot (5 bits per slot) |

## Verification
Pair formation and the four-slot cap can both act in one cycle. A fused pair frees a slot, so the window's fifth record is taken in the same cycle that the pair merges. The bench provokes this with windows where the pair sits at every position from 0 to 3, and with two eligible pairs in one window. It judges each case by comparing `take_cnt` and the full slot contents against expectations that a scoreboard model derives from the valid prefix and the earliest eligible pair.

// File: rtl/fg_pkg.sv
package fg_pkg;

  typedef enum logic [1:0] {
    CLS_PLAIN   = 2'd0,
    CLS_FLAGSET = 2'd1,
    CLS_JCC     = 2'd2,
    CLS_MISC    = 2'd3
  } ins_cls_e;

  // A flag-setting head directly followed by a conditional jump may merge.
  function automatic logic can_merge(input logic [1:0] head, input logic [1:0] tail);
    return (head == CLS_FLAGSET) && (tail == CLS_JCC);
  endfunction

endpackage

// File: rtl/fg_pair_detect.sv
module fg_pair_detect #(
  parameter int WIN   = 5,
  parameter int LEN_W = 4
) (
  input  logic             vld      [WIN],
  input  logic [1:0]       cls      [WIN],
  input  logic [LEN_W-1:0] len      [WIN],
  output logic             pair_ok  [WIN],
  output logic [LEN_W:0]   pair_len [WIN],
  output logic [LEN_W:0]   solo_len [WIN]
);
  import fg_pkg::*;

  for (genvar p = 0; p < WIN; p++) begin : g_pos
    assign solo_len[p] = {1'b0, len[p]};
    if (p < WIN - 1) begin : g_inner
      assign pair_ok[p]  = vld[p] && vld[p+1] && can_merge(cls[p], cls[p+1]);
      assign pair_len[p] = {1'b0, len[p]} + {1'b0, len[p+1]};
    end else begin : g_last
      // no partner is visible beyond the window
      assign pair_ok[p]  = 1'b0;
      assign pair_len[p] = {1'b0, len[p]};
    end
  end

endmodule

// File: rtl/fg_slot_packer.sv
module fg_slot_packer #(
  parameter int WIN    = 5,
  parameter int SLOTS  = 4,
  parameter int LEN_W  = 4,
  parameter int PIDX_W = $clog2(WIN),
  parameter int CNT_W  = $clog2(WIN + 1)
) (
  input  logic              vld      [WIN],
  input  logic              pair_ok  [WIN],
  input  logic [LEN_W:0]    pair_len [WIN],
  input  logic [LEN_W:0]    solo_len [WIN],
  output logic              s_vld    [SLOTS],
  output logic              s_fus    [SLOTS],
  output logic [PIDX_W-1:0] s_pos    [SLOTS],
  output logic [LEN_W:0]    s_len    [SLOTS],
  output logic [CNT_W-1:0]  take
);

  logic [CNT_W-1:0]  pos;
  logic [PIDX_W-1:0] idx;
  logic              fuse_spent;
  logic              halted;

  always_comb begin
    pos        = '0;
    idx        = '0;
    fuse_spent = 1'b0;
    halted     = 1'b0;
    for (int s = 0; s < SLOTS; s++) begin
      s_vld[s] = 1'b0;
      s_fus[s] = 1'b0;
      s_pos[s] = '0;
      s_len[s] = '0;
      idx      = pos[PIDX_W-1:0];
      if (!halted && (pos < CNT_W'(WIN))) begin
        if (!vld[idx]) begin
          halted = 1'b1;
        end else if (!fuse_spent && pair_ok[idx]) begin
          s_vld[s]   = 1'b1;
          s_fus[s]   = 1'b1;
          s_pos[s]   = idx;
          s_len[s]   = pair_len[idx];
          fuse_spent = 1'b1;
          pos        = pos + CNT_W'(2);
        end else begin
          s_vld[s] = 1'b1;
          s_pos[s] = idx;
          s_len[s] = solo_len[idx];
          pos      = pos + CNT_W'(1);
        end
      end
    end
    take = pos;
  end

endmodule

// File: rtl/fuse_grouper.sv
module fuse_grouper #(
  parameter int WIN    = 5,
  parameter int SLOTS  = 4,
  parameter int LEN_W  = 4,
  localparam int PIDX_W = $clog2(WIN),
  localparam int CNT_W  = $clog2(WIN + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [WIN-1:0]            rec_valid,
  input  logic [WIN*2-1:0]          rec_cls,
  input  logic [WIN*LEN_W-1:0]      rec_len,
  input  logic                      dec_ready,
  output logic [CNT_W-1:0]          take_cnt,
  output logic [SLOTS-1:0]          slot_valid,
  output logic [SLOTS-1:0]          slot_fused,
  output logic [SLOTS*PIDX_W-1:0]   slot_pos,
  output logic [SLOTS*(LEN_W+1)-1:0] slot_len
);

  logic              w_vld      [WIN];
  logic [1:0]        w_cls      [WIN];
  logic [LEN_W-1:0]  w_len      [WIN];
  logic              w_pair_ok  [WIN];
  logic [LEN_W:0]    w_pair_len [WIN];
  logic [LEN_W:0]    w_solo_len [WIN];

  logic              n_vld [SLOTS];
  logic              n_fus [SLOTS];
  logic [PIDX_W-1:0] n_pos [SLOTS];
  logic [LEN_W:0]    n_len [SLOTS];
  logic [CNT_W-1:0]  pk_take;

  for (genvar i = 0; i < WIN; i++) begin : g_unpack
    assign w_vld[i] = rec_valid[i];
    assign w_cls[i] = rec_cls[2*i +: 2];
    assign w_len[i] = rec_len[LEN_W*i +: LEN_W];
  end

  fg_pair_detect #(.WIN(WIN), .LEN_W(LEN_W)) detect_i (
    .vld      (w_vld),
    .cls      (w_cls),
    .len      (w_len),
    .pair_ok  (w_pair_ok),
    .pair_len (w_pair_len),
    .solo_len (w_solo_len)
  );

  fg_slot_packer #(.WIN(WIN), .SLOTS(SLOTS), .LEN_W(LEN_W)) packer_i (
    .vld      (w_vld),
    .pair_ok  (w_pair_ok),
    .pair_len (w_pair_len),
    .solo_len (w_solo_len),
    .s_vld    (n_vld),
    .s_fus    (n_fus),
    .s_pos    (n_pos),
    .s_len    (n_len),
    .take     (pk_take)
  );

  assign take_cnt = dec_ready ? pk_take : '0;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_valid[s]                    <= 1'b0;
        slot_fused[s]                    <= 1'b0;
        slot_pos[s*PIDX_W +: PIDX_W]     <= '0;
        slot_len[s*(LEN_W+1) +: LEN_W+1] <= '0;
      end else begin
        slot_valid[s]                    <= dec_ready && n_vld[s];
        slot_fused[s]                    <= dec_ready && n_fus[s];
        slot_pos[s*PIDX_W +: PIDX_W]     <= n_pos[s];
        slot_len[s*(LEN_W+1) +: LEN_W+1] <= n_len[s];
      end
    end
  end

  // Records represented by the presented slots, for the consumption check.
  logic [CNT_W-1:0] held_cnt;
  always_comb begin
    held_cnt = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (slot_valid[s]) held_cnt = held_cnt + (slot_fused[s] ? CNT_W'(2) : CNT_W'(1));
    end
  end

  // R4
  one_fuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_valid & slot_fused) <= 1);

  // R10
  take_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (held_cnt == $past(take_cnt)));

  // R9
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_ready |=> (slot_valid == '0));

  // R11
  packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_valid + SLOTS'(1)) & slot_valid) == '0);

  // R5
  bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_cnt <= CNT_W'(SLOTS + 1));

endmodule

// File: tb/fuse_grouper_tb_top.sv
module fuse_grouper_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rec_valid = '0;
  logic [9:0]  rec_cls = '0;
  logic [19:0] rec_len = '0;
  logic        dec_ready = 1'b0;
  logic [2:0]  take_cnt;
  logic [3:0]  slot_valid, slot_fused;
  logic [11:0] slot_pos;
  logic [19:0] slot_len;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [3:0]  v;
    logic [3:0]  f;
    logic [11:0] pos;
    logic [19:0] len;
    string       req;
  } exp_t;

  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fuse_grouper dut_i (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_cls(rec_cls),
    .rec_len(rec_len), .dec_ready(dec_ready), .take_cnt(take_cnt),
    .slot_valid(slot_valid), .slot_fused(slot_fused), .slot_pos(slot_pos),
    .slot_len(slot_len)
  );

  // Scoreboard model: valid prefix plus earliest eligible pair.
  function automatic exp_t model(input logic [4:0] v, input logic [9:0] c,
                                 input logic [19:0] l, input logic rdy,
                                 input string req, output int tk);
    exp_t e;
    int vp, pr, k, s;
    e.v = '0; e.f = '0; e.pos = '0; e.len = '0; e.req = req;
    vp = 0;
    while (vp < 5 && v[vp]) vp++;
    pr = -1;
    for (int p = 0; p < vp - 1; p++)
      if (pr < 0 && c[2*p +: 2] == 2'd1 && c[2*p+2 +: 2] == 2'd2) pr = p;
    s = 0;
    if (pr >= 0) begin
      for (int i = 0; i < pr; i++) begin
        e.v[s] = 1; e.pos[3*s +: 3] = 3'(i); e.len[5*s +: 5] = {1'b0, l[4*i +: 4]}; s++;
      end
      e.v[s] = 1; e.f[s] = 1; e.pos[3*s +: 3] = 3'(pr);
      e.len[5*s +: 5] = {1'b0, l[4*pr +: 4]} + {1'b0, l[4*pr+4 +: 4]}; s++;
      k = vp - pr - 2;
      if (k > 3 - pr) k = 3 - pr;
      for (int i = pr + 2; i < pr + 2 + k; i++) begin
        e.v[s] = 1; e.pos[3*s +: 3] = 3'(i); e.len[5*s +: 5] = {1'b0, l[4*i +: 4]}; s++;
      end
      tk = pr + 2 + k;
    end else begin
      k = (vp < 4) ? vp : 4;
      for (int i = 0; i < k; i++) begin
        e.v[s] = 1; e.pos[3*s +: 3] = 3'(i); e.len[5*s +: 5] = {1'b0, l[4*i +: 4]}; s++;
      end
      tk = k;
    end
    if (!rdy) begin
      tk = 0; e.v = '0; e.f = '0; e.pos = '0; e.len = '0;
    end
    return e;
  endfunction

  task automatic drive(input logic [4:0] v, input int c0, input int c1, input int c2,
                       input int c3, input int c4, input logic rdy, input string req);
    exp_t e;
    int tk;
    logic [9:0] c;
    logic [19:0] l;
    c = {2'(c4), 2'(c3), 2'(c2), 2'(c1), 2'(c0)};
    for (int i = 0; i < 5; i++) l[4*i +: 4] = 4'((i * 3 + checks) % 15 + 1);
    @(negedge clk);
    rec_valid = v; rec_cls = c; rec_len = l; dec_ready = rdy;
    e = model(v, c, l, rdy, req, tk);
    #1;
    checks++;
    if (take_cnt !== 3'(tk)) begin
      fails++;
      $display("FAIL %s take_cnt actual=%0d expected=%0d", req, take_cnt, tk);
    end
    sb.push_back(e);
  endtask

  // Monitor: slots appear one edge after the inputs were applied.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (slot_valid !== e.v || (slot_fused & slot_valid) !== e.f ||
            (slot_pos & {{3{e.v[3]}}, {3{e.v[2]}}, {3{e.v[1]}}, {3{e.v[0]}}}) !== e.pos ||
            (slot_len & {{5{e.v[3]}}, {5{e.v[2]}}, {5{e.v[1]}}, {5{e.v[0]}}}) !== e.len) begin
          fails++;
          $display("FAIL %s slots actual v=%b f=%b pos=%h len=%h expected v=%b f=%b pos=%h len=%h",
                   e.req, slot_valid, slot_fused, slot_pos, slot_len, e.v, e.f, e.pos, e.len);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++;  // R1
    if (slot_valid !== 4'b0) begin
      fails++;
      $display("FAIL R1 slot_valid actual=%b expected=0000", slot_valid);
    end
    drive(5'b11111, 0, 0, 3, 0, 0, 1, "R2 plain window");
    drive(5'b11111, 1, 2, 0, 0, 0, 1, "R3 pair at 0, R5 five taken");
    drive(5'b11111, 0, 0, 1, 2, 0, 1, "R3 pair at 2");
    drive(5'b11111, 0, 0, 0, 1, 2, 1, "R3 pair at 3 R5");
    drive(5'b11111, 1, 2, 1, 2, 0, 1, "R4 second pair unfused");
    drive(5'b11111, 0, 1, 2, 1, 2, 1, "R4 two pairs offset");
    drive(5'b01111, 0, 0, 0, 1, 2, 1, "R7 partner invalid");
    drive(5'b00011, 0, 1, 0, 0, 0, 1, "R7 head at end of prefix");
    drive(5'b11011, 1, 2, 0, 0, 0, 1, "R6 gap stops taking");
    drive(5'b11110, 0, 0, 0, 0, 0, 1, "R6 four valid");
    drive(5'b11111, 2, 1, 0, 1, 3, 1, "R8 jump first, head before plain");
    drive(5'b11111, 1, 1, 2, 0, 0, 1, "R8 double head then pair");
    drive(5'b11111, 3, 2, 2, 1, 1, 1, "R8 no eligible order");
    drive(5'b11111, 1, 2, 0, 0, 0, 0, "R9 stalled");
    drive(5'b11111, 0, 1, 2, 0, 0, 1, "R10 after stall");
    drive(5'b00000, 0, 0, 0, 0, 0, 1, "R6 empty window");
    drive(5'b11111, 0, 0, 0, 0, 1, 1, "R7 head at last position");
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule